// File: doc/BRIEF.md
# Packet-Aware Stream Flusher

This stage sits in a valid/ready stream between a producer and a downstream FIFO. In normal operation it passes every beat through unchanged, with no added latency: valid, start-of-packet, end-of-packet, data and channel reach the sink in the same cycle, and the producer sees the sink's ready. When the flush-enable input is raised, the stage drains the stream instead. It holds upstream ready high and throws away every beat it accepts, so the producer never stalls while the sink receives nothing.

Two build-time options decide how flushing starts and stops. With framed entry, a packet that is already being forwarded runs to its end-of-packet beat before any beat is dropped. With framed exit, a drop phase continues after flush-enable falls and ends only when a start-of-packet beat arrives, and that beat is forwarded. With both options set, the sink only ever sees whole packets. With both cleared, the stage follows flush-enable cycle for cycle. Both ends use ready latency 0, so a beat transfers in any cycle where valid and ready are both high. The stage runs on one clock with an active-low asynchronous reset.

Top module: `stream_flusher`

## Requirements
- R1: After reset the stage forwards. With no beat offered, out_valid is 0 and in_ready equals out_ready.
- R2: While forwarding, in_ready equals out_ready and out_valid, out_sop, out_eop, out_data and out_channel equal the matching inputs in the same cycle.
- R3: While dropping, in_ready is 1 whatever out_ready is, out_valid is 0, and no accepted beat ever appears at the output.
- R4: With FRAMED_ENTRY=0, dropping starts in the first cycle flush_en is 1, even in the middle of a packet.
- R5: With FRAMED_ENTRY=1 and flush_en raised inside a packet (a start-of-packet beat was accepted and its end-of-packet beat was not), the remaining beats up to and including the end-of-packet beat are forwarded, and dropping starts after that.
- R6: With FRAMED_ENTRY=1 and flush_en raised between packets, dropping starts in that same cycle.
- R7: With FRAMED_EXIT=0, out_valid equals in_valid in every cycle where flush_en is 0.
- R8: With FRAMED_EXIT=1, dropping continues after flush_en falls until a beat with in_sop=1 is offered. That beat is forwarded in its own cycle.
- R9: With both options set to 1, every packet at the output starts with a start-of-packet beat and closes with an end-of-packet beat, and no beat appears outside a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_en | input | 1 | Request to drain the stream |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream ready (latency 0) |
| in_sop | input | 1 | Upstream start-of-packet marker |
| in_eop | input | 1 | Upstream end-of-packet marker |
| in_data | input | DATA_W | Upstream payload |
| in_channel | input | CHAN_W | Upstream channel number |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream ready (latency 0) |
| out_sop | output | 1 | Downstream start-of-packet marker |
| out_eop | output | 1 | Downstream end-of-packet marker |
| out_data | output | DATA_W | Downstream payload |
| out_channel | output | CHAN_W | Downstream channel number |

## Verification
The hardest cases to reach are the cycles where flush_en changes while a packet is still open on one side of the stage. Framed entry must keep forwarding to the end-of-packet beat, and framed exit must keep dropping through the tail of an interrupted packet, across idle cycles, until the next start-of-packet beat. The bench drives a fixed beat sequence into two instances, one with both options set and one with both cleared. It toggles flush_en on chosen mid-packet beats and on an idle gap, and it tags each beat with the forward or drop result expected from each build. A scoreboard then matches what leaves each instance. A separate step stalls the sink with a beat pending, to show that ready follows the sink while forwarding and is forced high while dropping.

// File: rtl/flush_pkg.sv
package flush_pkg;

    typedef enum logic {
        MODE_PASS = 1'b0,
        MODE_DROP = 1'b1
    } flush_mode_e;

    typedef struct packed {
        flush_mode_e mode;
    } ctrl_reg_t;

    typedef struct packed {
        logic open;
    } track_reg_t;

endpackage

// File: rtl/flush_pkt_track.sv
// Tracks whether the upstream stream is inside a packet, counting every
// accepted beat, whether it was forwarded or dropped.
module flush_pkt_track
    import flush_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat_take,
    input  logic beat_sop,
    input  logic beat_eop,
    output logic in_pkt
);

    track_reg_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (beat_take) begin
            if (beat_eop) begin
                trk_d.open = 1'b0;
            end else if (beat_sop) begin
                trk_d.open = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign in_pkt = trk_q.open;

endmodule

// File: rtl/flush_ctrl.sv
// Decides in each cycle whether beats are dropped, applying the framing
// options on entry and on exit.
module flush_ctrl
    import flush_pkg::*;
#(
    parameter bit FRAMED_ENTRY = 1'b1,
    parameter bit FRAMED_EXIT  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_en,
    input  logic in_pkt,
    input  logic in_valid,
    input  logic in_sop,
    output logic dropping
);

    ctrl_reg_t ctl_d, ctl_q;
    logic      entry_ok;
    logic      drop_req;
    logic      hold_exit;

    always_comb begin
        entry_ok  = !FRAMED_ENTRY || !in_pkt;
        drop_req  = flush_en && ((ctl_q.mode == MODE_DROP) || entry_ok);
        hold_exit = FRAMED_EXIT && (ctl_q.mode == MODE_DROP) && !flush_en
                    && !(in_valid && in_sop);
        dropping  = drop_req || hold_exit;
        ctl_d     = ctl_q;
        ctl_d.mode = dropping ? MODE_DROP : MODE_PASS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{mode: MODE_PASS};
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/flush_gate.sv
// Handshake gate at ready latency 0 on both sides: it either forwards a
// beat or accepts it and discards it.
module flush_gate #(
    parameter int DATA_W = 32,
    parameter int CHAN_W = 4
) (
    input  logic              dropping,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CHAN_W-1:0] in_channel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    output logic [CHAN_W-1:0] out_channel,
    output logic              beat_take
);

    always_comb begin
        in_ready    = dropping ? 1'b1 : out_ready;
        out_valid   = in_valid && !dropping;
        out_sop     = in_sop;
        out_eop     = in_eop;
        out_data    = in_data;
        out_channel = in_channel;
        beat_take   = in_valid && in_ready;
    end

endmodule

// File: rtl/stream_flusher.sv
module stream_flusher
    import flush_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int CHAN_W       = 4,
    parameter bit FRAMED_ENTRY = 1'b1,
    parameter bit FRAMED_EXIT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CHAN_W-1:0] in_channel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    output logic [CHAN_W-1:0] out_channel
);

    logic dropping;
    logic in_pkt;
    logic beat_take;

    flush_ctrl #(
        .FRAMED_ENTRY (FRAMED_ENTRY),
        .FRAMED_EXIT  (FRAMED_EXIT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_en (flush_en),
        .in_pkt   (in_pkt),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .dropping (dropping)
    );

    flush_pkt_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_take (beat_take),
        .beat_sop  (in_sop),
        .beat_eop  (in_eop),
        .in_pkt    (in_pkt)
    );

    flush_gate #(
        .DATA_W (DATA_W),
        .CHAN_W (CHAN_W)
    ) u_gate (
        .dropping    (dropping),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_sop      (in_sop),
        .in_eop      (in_eop),
        .in_data     (in_data),
        .in_channel  (in_channel),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_sop     (out_sop),
        .out_eop     (out_eop),
        .out_data    (out_data),
        .out_channel (out_channel),
        .beat_take   (beat_take)
    );

endmodule

// File: rtl/stream_flusher_chk.sv
module stream_flusher_chk #(
    parameter int DATA_W       = 32,
    parameter int CHAN_W       = 4,
    parameter bit FRAMED_ENTRY = 1'b1,
    parameter bit FRAMED_EXIT  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_en,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_sop,
    input logic [DATA_W-1:0] in_data,
    input logic [CHAN_W-1:0] in_channel,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_sop,
    input logic              out_eop,
    input logic [DATA_W-1:0] out_data,
    input logic [CHAN_W-1:0] out_channel
);

    logic dn_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dn_open <= 1'b0;
        end else if (out_valid && out_ready) begin
            if (out_eop) begin
                dn_open <= 1'b0;
            end else if (out_sop) begin
                dn_open <= 1'b1;
            end
        end
    end

    assert_pass_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_ready == out_ready) && (out_data == in_data)
                      && (out_channel == in_channel) && (out_sop == in_sop));

    assert_drop_accepts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_valid) |-> in_ready);

    assert_no_phantom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);

    assert_instant_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!FRAMED_ENTRY && flush_en) |-> !out_valid);

    assert_instant_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!FRAMED_EXIT && !flush_en) |-> (out_valid == in_valid));

    assert_exit_on_sop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (FRAMED_EXIT && out_valid && $past(in_valid && !out_valid && !flush_en))
        |-> out_sop);

    assert_whole_packets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (FRAMED_ENTRY && FRAMED_EXIT && out_valid) |-> (out_sop == !dn_open));

endmodule

bind stream_flusher stream_flusher_chk #(
    .DATA_W       (DATA_W),
    .CHAN_W       (CHAN_W),
    .FRAMED_ENTRY (FRAMED_ENTRY),
    .FRAMED_EXIT  (FRAMED_EXIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_en    (flush_en),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_sop      (in_sop),
    .in_data     (in_data),
    .in_channel  (in_channel),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_data    (out_data),
    .out_channel (out_channel)
);

// File: tb/stream_flusher_tb.sv
`timescale 1ns/1ps
module stream_flusher_tb;

    localparam int DW = 8;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_en = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [CW-1:0] in_channel = 2'd1;
    logic          out_ready = 1'b1;

    logic          rdy_f, ov_f, os_f, oe_f;
    logic [DW-1:0] od_f;
    logic [CW-1:0] oc_f;
    logic          rdy_i, ov_i, os_i, oe_i;
    logic [DW-1:0] od_i;
    logic [CW-1:0] oc_i;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW+1:0] q_f[$];
    logic [DW+1:0] q_i[$];
    bit open_f = 1'b0;

    always #2.5 clk = ~clk;

    stream_flusher #(.DATA_W(DW), .CHAN_W(CW), .FRAMED_ENTRY(1'b1), .FRAMED_EXIT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush_en(flush_en),
        .in_valid(in_valid), .in_ready(rdy_f), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_channel(in_channel),
        .out_valid(ov_f), .out_ready(out_ready), .out_sop(os_f), .out_eop(oe_f),
        .out_data(od_f), .out_channel(oc_f));

    stream_flusher #(.DATA_W(DW), .CHAN_W(CW), .FRAMED_ENTRY(1'b0), .FRAMED_EXIT(1'b0)) u_dut_imm (
        .clk(clk), .rst_n(rst_n), .flush_en(flush_en),
        .in_valid(in_valid), .in_ready(rdy_i), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_channel(in_channel),
        .out_valid(ov_i), .out_ready(out_ready), .out_sop(os_i), .out_eop(oe_i),
        .out_data(od_i), .out_channel(oc_i));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: offers one beat and records which instance must forward it.
    task automatic beat(input logic fe, input logic s, input logic e,
                        input logic [DW-1:0] d, input bit xf, input bit xi);
        @(posedge clk); #1;
        flush_en = fe; in_valid = 1'b1; in_sop = s; in_eop = e; in_data = d;
        if (xf) q_f.push_back({s, e, d});
        if (xi) q_i.push_back({s, e, d});
        @(negedge clk);
        chk(rdy_f == 1'b1, "R2 R3 in_ready u_dut", int'(rdy_f), 1);
        chk(rdy_i == 1'b1, "R2 R3 in_ready u_dut_imm", int'(rdy_i), 1);
    endtask

    task automatic idle(input logic fe);
        @(posedge clk); #1;
        flush_en = fe; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    // Monitor: pops and compares every beat that leaves each instance.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ov_f && out_ready) begin
                if (q_f.size() == 0) begin
                    chk(1'b0, "R3 u_dut unexpected beat", int'(od_f), -1);
                end else begin
                    logic [DW+1:0] ef;
                    ef = q_f.pop_front();
                    chk({os_f, oe_f, od_f} == ef, "R3 R5 R6 R8 u_dut beat",
                        int'({os_f, oe_f, od_f}), int'(ef));
                end
                // R9: packet framing at the output of the fully framed build
                chk(os_f == !open_f, "R9 u_dut sop framing", int'(os_f), int'(!open_f));
                if (oe_f) open_f = 1'b0;
                else if (os_f) open_f = 1'b1;
            end
            if (ov_i && out_ready) begin
                if (q_i.size() == 0) begin
                    chk(1'b0, "R4 u_dut_imm unexpected beat", int'(od_i), -1);
                end else begin
                    logic [DW+1:0] ei;
                    ei = q_i.pop_front();
                    chk({os_i, oe_i, od_i} == ei, "R4 R7 u_dut_imm beat",
                        int'({os_i, oe_i, od_i}), int'(ei));
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: forwarding after reset, nothing held
        chk(ov_f == 1'b0 && ov_i == 1'b0, "R1 out_valid after reset", int'({ov_f, ov_i}), 0);
        chk(rdy_f == 1'b1 && rdy_i == 1'b1, "R1 in_ready follows out_ready", int'({rdy_f, rdy_i}), 3);

        // Packet A: plain forwarding (R2)
        beat(0, 1, 0, 8'd1, 1, 1);
        beat(0, 0, 0, 8'd2, 1, 1);
        beat(0, 0, 1, 8'd3, 1, 1);
        // Packet B: flush raised mid-packet. Framed finishes it (R5), immediate drops (R4)
        beat(0, 1, 0, 8'd4, 1, 1);
        beat(1, 0, 0, 8'd5, 1, 0);
        beat(1, 0, 1, 8'd6, 1, 0);
        // Packet C: flush between packets drops at once (R6); flush released before the tail
        beat(1, 1, 0, 8'd7, 0, 0);
        beat(1, 0, 0, 8'd8, 0, 0);
        beat(0, 0, 1, 8'd9, 0, 1);   // R8 framed keeps dropping, R7 immediate forwards
        idle(0);                     // R8 gap with no start-of-packet
        // Packet D: start-of-packet ends the framed drop and is forwarded (R8)
        beat(0, 1, 0, 8'd10, 1, 1);
        beat(0, 0, 1, 8'd11, 1, 1);
        // Packet E: short flush on the sop only
        beat(1, 1, 0, 8'd12, 0, 0);
        beat(0, 0, 0, 8'd13, 0, 1);
        beat(0, 0, 1, 8'd14, 0, 1);
        // Packet F: single-beat packet, then a normal one
        beat(0, 1, 1, 8'd15, 1, 1);
        beat(0, 1, 0, 8'd16, 1, 1);
        beat(0, 0, 1, 8'd17, 1, 1);

        // Sink stall with a beat pending: forwarding passes ready through (R2)
        @(posedge clk); #1;
        flush_en = 1'b0; in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0;
        in_data = 8'h5A; out_ready = 1'b0;
        #1;
        chk(rdy_f == 1'b0 && rdy_i == 1'b0, "R2 ready passes stall", int'({rdy_f, rdy_i}), 0);
        chk(ov_f && od_f == 8'h5A && oc_f == 2'd1, "R2 u_dut fields", int'(od_f), 8'h5A);
        chk(ov_i && od_i == 8'h5A && oc_i == 2'd1, "R2 u_dut_imm fields", int'(od_i), 8'h5A);
        flush_en = 1'b1;
        #1;
        // R3: dropping holds in_ready high although the sink is stalled
        chk(rdy_f == 1'b1 && rdy_i == 1'b1, "R3 ready high while dropping", int'({rdy_f, rdy_i}), 3);
        chk(ov_f == 1'b0 && ov_i == 1'b0, "R3 no output while dropping", int'({ov_f, ov_i}), 0);
        in_valid = 1'b0; flush_en = 1'b0; out_ready = 1'b1;

        idle(0);
        idle(0);
        @(negedge clk);
        chk(q_f.size() == 0, "R5 R8 u_dut queue drained", q_f.size(), 0);
        chk(q_i.size() == 0, "R4 R7 u_dut_imm queue drained", q_i.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule